// File: doc/BRIEF.md
# Timer Clock Source Select and Prescaler

This block sits in front of an interval timer. An 8-bit control word picks which clock enable the timer runs from and how far that enable is divided down before the timer counts on it. The possible sources are three internal single-cycle enables and two external pins. Each external pin is synchronised and edge-detected before use. One select code turns the source off, and two more codes are reserved and also leave it off.

The selected enable advances a 12-bit prescale counter. A tap code picks one of eight divide ratios: 2, 4, 8, 16, 32, 256, 1024 and 4096. When the counter reaches the end of a period, the block issues a one-cycle tick that serves as the timer's count enable. Any write to the control word restarts the counter, so a new ratio begins at a known phase.

The control word also holds a local interrupt enable. The block combines it with a global enable and the timer's flag to form the interrupt request.

Top module: `tmr_clksel_prescale`

## Requirements
- R1: After reset the control word reads 0x00. A write stores bits 7, 5:3 and 2:0, which read back next cycle. Bit 6 always reads 0, whatever value is written to it.
- R2: With source code 000 (bits 5:3) no input enable advances the prescaler, and tick_en stays low.
- R3: Source codes 001, 010 and 011 select src_t0_en, src_io_en and src_aux_en. Each cycle the chosen input is high counts as one source pulse.
- R4: Source codes 100 and 101 select ext_a_in and ext_b_in. Each pin passes through a two-flop synchroniser and a rising-edge detector. A rising level on the pin gives exactly one source pulse, three clocks after the pin is sampled high.
- R5: Source codes 110 and 111 behave exactly like code 000.
- R6: Tap codes 000 to 111 (bits 2:0) divide the source by 2, 4, 8, 16, 32, 256, 1024 and 4096 respectively. One tick is issued per that many source pulses.
- R7: tick_en is high for a single cycle: the cycle after the source pulse that completes a period.
- R8: A write clears the prescale count and suppresses tick_en in the following cycle. The next tick then needs a full period of pulses.
- R9: irq_req is high exactly when control bit 7, glb_irq_en and tmr_flag are all high.
- R10: At ratio 4096 the 12-bit count wraps cleanly, giving successive ticks exactly 4096 pulses apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 8 | Control word write data |
| rd_data | output | 8 | Control word read data |
| src_t0_en | input | 1 | Internal enable from timer 0 |
| src_io_en | input | 1 | Internal enable at the I/O clock rate |
| src_aux_en | input | 1 | Third internal clock enable |
| ext_a_in | input | 1 | First external count input (asynchronous) |
| ext_b_in | input | 1 | Second external count input (asynchronous) |
| glb_irq_en | input | 1 | Global interrupt enable |
| tmr_flag | input | 1 | Timer event flag |
| tick_en | output | 1 | One-cycle prescaled count enable |
| irq_req | output | 1 | Interrupt request |

## Verification
The embedded assertions check these on every cycle: a write is stored and read back, a write clears the count, the count holds when no pulse is selected, disabled and reserved codes select nothing, and each tick follows a source pulse. Only the bench's scenarios can show that ticks land at the exact ratio for each tap code, that the external inputs have their three-clock latency, and that the count wraps correctly at 4096. The bench covers these with a cycle model driven by random sources, writes and pin toggles, plus directed runs on every tap.

// File: rtl/tcp_pkg.sv
package tcp_pkg;

   localparam int CTRL_W   = 8;
   localparam int SEL_W    = 3;
   localparam int NUM_SRC  = 5;
   localparam int MAX_SHIFT = 12;

   typedef enum logic [SEL_W-1:0] {
      SRC_OFF  = 3'd0,
      SRC_T0   = 3'd1,
      SRC_IO   = 3'd2,
      SRC_AUX  = 3'd3,
      SRC_EXTA = 3'd4,
      SRC_EXTB = 3'd5,
      SRC_RSV6 = 3'd6,
      SRC_RSV7 = 3'd7
   } src_sel_e;

   typedef struct packed {
      logic             irq_en;
      logic             spare;
      logic [SEL_W-1:0] src;
      logic [SEL_W-1:0] tap;
   } ctrl_t;

   // log2 of the divide ratio for each tap code
   function automatic int unsigned tap_shift(input logic [SEL_W-1:0] code);
      case (code)
         3'd0:    return 1;
         3'd1:    return 2;
         3'd2:    return 3;
         3'd3:    return 4;
         3'd4:    return 5;
         3'd5:    return 8;
         3'd6:    return 10;
         default: return 12;
      endcase
   endfunction

endpackage

// File: rtl/tcp_ext_sync.sv
module tcp_ext_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_in,
   output logic rise_pulse
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tcp_ext_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= pin_in;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= chain_q[STAGES-1];
   end

   assign rise_pulse = chain_q[STAGES-1] & ~last_q;

   // R4
   one_pulse_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/tcp_src_mux.sv
module tcp_src_mux
   import tcp_pkg::*;
#(
   parameter int SRCS = NUM_SRC
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [SRCS-1:0]  src_vec,
   output logic             src_en
);
   if (SRCS >= (1 << SEL_W)) begin : g_bad_srcs
      $error("tcp_src_mux: code 0 must stay free for the off state");
   end

   logic [SRCS-1:0] hit;

   for (genvar i = 0; i < SRCS; i++) begin : g_dec
      assign hit[i] = (sel == SEL_W'(i + 1)) & src_vec[i];
   end

   always_comb src_en = |hit;

   // R5
   always_comb begin
      off_codes_quiet_chk: assert (!((sel == 3'd0 || int'(sel) > SRCS) && src_en));
   end

endmodule

// File: rtl/tcp_prescaler.sv
module tcp_prescaler
   import tcp_pkg::*;
#(
   parameter int CNT_W      = 12,
   parameter bit REG_OUTPUT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   input  logic [SEL_W-1:0] tap,
   output logic             tick
);
   if (CNT_W < MAX_SHIFT) begin : g_bad_width
      $error("tcp_prescaler: CNT_W too small for the largest tap");
   end

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] mask;
   logic             wrap;

   always_comb begin
      mask = (ONE << tap_shift(tap)) - ONE;
      wrap = step & ((cnt_q & mask) == mask);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + ONE;
   end

   if (REG_OUTPUT) begin : g_reg_tick
      logic tick_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   tick_q <= 1'b0;
         else if (clr) tick_q <= 1'b0;
         else          tick_q <= wrap;
      end
      assign tick = tick_q;

      // R7
      tick_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |-> $past(step));
   end else begin : g_comb_tick
      assign tick = wrap & ~clr;
   end

   // R8
   clear_zeroes_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0));

   // R2
   hold_without_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(cnt_q));

endmodule

// File: rtl/tmr_clksel_prescale.sv
module tmr_clksel_prescale
   import tcp_pkg::*;
#(
   parameter int CNT_W       = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   output logic [7:0] rd_data,
   input  logic       src_t0_en,
   input  logic       src_io_en,
   input  logic       src_aux_en,
   input  logic       ext_a_in,
   input  logic       ext_b_in,
   input  logic       glb_irq_en,
   input  logic       tmr_flag,
   output logic       tick_en,
   output logic       irq_req
);
   ctrl_t           ctrl_q;
   logic [1:0]      ext_pin;
   logic [1:0]      ext_rise;
   logic [NUM_SRC-1:0] src_vec;
   logic            src_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q.irq_en <= wr_data[7];
         ctrl_q.spare  <= 1'b0;
         ctrl_q.src    <= wr_data[5:3];
         ctrl_q.tap    <= wr_data[2:0];
      end
   end

   assign rd_data = {ctrl_q.irq_en, 1'b0, ctrl_q.src, ctrl_q.tap};

   assign ext_pin = {ext_b_in, ext_a_in};

   for (genvar e = 0; e < 2; e++) begin : g_ext
      tcp_ext_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk        (clk),
         .rst_n      (rst_n),
         .pin_in     (ext_pin[e]),
         .rise_pulse (ext_rise[e])
      );
   end

   assign src_vec = {ext_rise[1], ext_rise[0], src_aux_en, src_io_en, src_t0_en};

   tcp_src_mux #(.SRCS(NUM_SRC)) u_mux (
      .sel     (ctrl_q.src),
      .src_vec (src_vec),
      .src_en  (src_en)
   );

   tcp_prescaler #(.CNT_W(CNT_W), .REG_OUTPUT(1'b1)) u_pre (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (wr_en),
      .step  (src_en),
      .tap   (ctrl_q.tap),
      .tick  (tick_en)
   );

   assign irq_req = ctrl_q.irq_en & glb_irq_en & tmr_flag;

   // R1
   write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == ($past(wr_data) & 8'hBF)));

   // R8
   write_kills_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !tick_en);

   // R5
   reserved_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && ctrl_q.src >= 3'd6) |=> !tick_en);

endmodule

// File: tb/tmr_clksel_prescale_test.sv
module tmr_clksel_prescale_test;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic       src_t0_en = 1'b0, src_io_en = 1'b0, src_aux_en = 1'b0;
   logic       ext_a_in = 1'b0, ext_b_in = 1'b0;
   logic       glb_irq_en = 1'b0, tmr_flag = 1'b0;
   logic       tick_en, irq_req;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tmr_clksel_prescale uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
      .src_t0_en(src_t0_en), .src_io_en(src_io_en), .src_aux_en(src_aux_en),
      .ext_a_in(ext_a_in), .ext_b_in(ext_b_in), .glb_irq_en(glb_irq_en),
      .tmr_flag(tmr_flag), .tick_en(tick_en), .irq_req(irq_req)
   );

   // reference model state
   logic [7:0]  m_reg = '0;
   logic [11:0] m_cnt = '0;
   logic        m_tick = 1'b0;
   logic        a1 = 0, a2 = 0, ap = 0, b1 = 0, b2 = 0, bp = 0;
   string       cur_tag = "R6";
   int          tick_seen = 0;
   logic        prev_tick = 1'b0;

   function automatic int ratio_shift(input logic [2:0] t);
      case (t)
         3'd0: return 1;  3'd1: return 2;  3'd2: return 3;  3'd3: return 4;
         3'd4: return 5;  3'd5: return 8;  3'd6: return 10; default: return 12;
      endcase
   endfunction

   function automatic string src_tag(input logic [2:0] s);
      if (s == 3'd0) return "R2";
      if (s <= 3'd3) return "R3";
      if (s <= 3'd5) return "R4";
      return "R5";
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input bit wr, input logic [7:0] wd, input logic [2:0] srcs,
                       input bit ea, input bit eb, input bit g, input bit f);
      logic        en;
      logic [11:0] mask;
      string       tag;
      wr_en = wr; wr_data = wd;
      {src_aux_en, src_io_en, src_t0_en} = srcs;
      ext_a_in = ea; ext_b_in = eb; glb_irq_en = g; tmr_flag = f;
      #1;
      // R9
      check("R9", int'(irq_req), int'(m_reg[7] & g & f));
      case (m_reg[5:3])
         3'd1: en = srcs[0];
         3'd2: en = srcs[1];
         3'd3: en = srcs[2];
         3'd4: en = a2 & ~ap;
         3'd5: en = b2 & ~bp;
         default: en = 1'b0;
      endcase
      mask = 12'((13'd1 << ratio_shift(m_reg[2:0])) - 13'd1);
      ap = a2; a2 = a1; a1 = ea;
      bp = b2; b2 = b1; b1 = eb;
      if (wr) begin
         m_reg = wd & 8'hBF; m_cnt = '0; m_tick = 1'b0;
      end else begin
         m_tick = en && ((m_cnt & mask) == mask);
         m_cnt = m_cnt + 12'(en);
      end
      @(negedge clk);
      tag = wr ? "R8" : cur_tag;
      check(tag, int'(tick_en), int'(m_tick));
      check("R1", int'(rd_data), int'(m_reg));
      if (tick_en) tick_seen++;
      if (m_reg[2:0] != 3'd0 || m_reg[5:3] > 3'd3) begin
         // R7: never two ticks back to back at any ratio above 2 or slow sources
         if (prev_tick && tick_en) check("R7", 1, 0);
      end
      prev_tick = tick_en;
   endtask

   task automatic idle(input int n, input logic [2:0] srcs);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, srcs, ext_a_in, ext_b_in, 1'b0, 1'b0);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 190000);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      int unsigned seed_val;
      logic [7:0] wv;
      seed_val = $urandom(32'd2718);
      repeat (3) @(negedge clk);
      // reset state, R1
      check("R1", int'(rd_data), 0);
      check("R7", int'(tick_en), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reserved bit written as one reads zero
      step(1'b1, 8'hFF, 3'b000, 0, 0, 1, 1);
      check("R1", int'(rd_data[6]), 0);
      step(1'b1, 8'h00, 3'b000, 0, 0, 0, 0);

      // R2: source off, all inputs toggling
      cur_tag = "R2";
      step(1'b1, {2'b00, 3'd0, 3'd0}, 3'b000, 0, 0, 0, 0);
      for (int i = 0; i < 40; i++) step(1'b0, 8'h00, 3'b111, i[0], i[1], 0, 0);
      check("R2", tick_seen, 0);

      // R5: reserved codes
      cur_tag = "R5";
      for (int c = 6; c < 8; c++) begin
         step(1'b1, {2'b00, 3'(c), 3'd0}, 3'b000, 0, 0, 0, 0);
         tick_seen = 0;
         for (int i = 0; i < 40; i++) step(1'b0, 8'h00, 3'b111, i[0], i[1], 0, 0);
         check("R5", tick_seen, 0);
      end

      // R6 / R10: each tap, I/O enable held high, two periods
      for (int t = 0; t < 8; t++) begin
         int r;
         r = 1 << ratio_shift(3'(t));
         cur_tag = (t == 7) ? "R10" : "R6";
         step(1'b1, {2'b00, 3'd2, 3'(t)}, 3'b000, 0, 0, 0, 0);
         tick_seen = 0;
         idle(2 * r, 3'b010);
         check(cur_tag, tick_seen, 2);
      end

      // R4: external pin edges with tap /2
      cur_tag = "R4";
      step(1'b1, {2'b00, 3'd4, 3'd0}, 3'b000, 0, 0, 0, 0);
      tick_seen = 0;
      for (int k = 0; k < 4; k++) begin
         for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 3'b000, 1, 0, 0, 0);
         for (int i = 0; i < 6; i++) step(1'b0, 8'h00, 3'b000, 0, 0, 0, 0);
      end
      check("R4", tick_seen, 2);

      // R8: write mid-period restarts count
      cur_tag = "R8";
      step(1'b1, {2'b00, 3'd1, 3'd2}, 3'b000, 0, 0, 0, 0);
      idle(5, 3'b001);
      step(1'b1, {2'b00, 3'd1, 3'd2}, 3'b001, 0, 0, 0, 0);
      tick_seen = 0;
      idle(7, 3'b001);
      check("R8", tick_seen, 0);
      idle(1, 3'b001);
      check("R8", tick_seen, 1);

      // random mix: R3, R4, R9 and others
      for (int seg = 0; seg < 24; seg++) begin
         wv = 8'($urandom);
         if (seg % 3 == 0) wv[2:0] = 3'($urandom % 3);
         cur_tag = src_tag(wv[5:3]);
         step(1'b1, wv, 3'($urandom), ext_a_in, ext_b_in, 1'($urandom), 1'($urandom));
         for (int i = 0; i < 300; i++) begin
            logic ea, eb;
            ea = ($urandom % 3 == 0) ? ~ext_a_in : ext_a_in;
            eb = ($urandom % 3 == 0) ? ~ext_b_in : ext_b_in;
            step(($urandom % 97) == 0, 8'($urandom) & 8'hC7 | (wv & 8'h38),
                 3'($urandom), ea, eb, 1'($urandom), 1'($urandom));
         end
      end

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule